// File: doc/BRIEF.md
# Synchronous Clock Stop Gate

This block sits between a clock source and a group of clock outputs and stops or runs each output in response to an active-low, asynchronous stop request. It never produces a shortened or lengthened pulse. Each output has two control bits. The stoppable bit decides whether the output halts while the request is active or keeps running through it. The enable bit switches the output off permanently, whatever the state of the request.

Each output drives a true leg and a complement leg. Outputs are built in one of two classes, chosen by a parameter mask. A float-class output (for example a processor clock pair) releases its drive, both legs low with output enable deasserted, when it is stopped. A low-class output (for example a bus clock) keeps driving and is simply held low. The request passes through a two-stage synchronizer on the rising edge. The true-leg gate moves only on the falling edge, while the clock is low. The complement-leg gate moves only on the rising edge, while the complement is low.

Top module: `clk_stop_gate`

## Requirements
- R1: After stop_ni falls, a running stoppable output still gives full high pulses on the first and second rising edges of clk_i. From the third rising edge onward its true leg stays low.
- R2: After stop_ni rises, a stopped output stays low on the first and second rising edges of clk_i. It gives a full high pulse again from the third rising edge.
- R3: An enabled output whose bit in stoppable_i is 0 keeps running while stop_ni is low, as if no request were present.
- R4: An output whose bit in enable_i is 0 holds its true and complement legs low, whatever stop_ni and stoppable_i are.
- R5: A float-class output (bit i of FLOAT_MASK = 1) drives oe_o[i] = 0 whenever it is stopped or disabled. A low-class output always drives oe_o[i] = 1.
- R6: clk_o is low whenever clk_i is low. Each high phase of clk_o is a complete high phase of clk_i.
- R7: clkb_o[i] is the inverted clock while output i runs, and is low whenever clk_i is high. On a stop, the complement gives its last pulse in the low phase that follows the true leg's last pulse.
- R8: While rst_ni is low, clk_o and clkb_o are all low, oe_o equals ~FLOAT_MASK, and the synchronizer reads "no stop".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock to be gated |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_ni | input | 1 | Asynchronous stop request, active low |
| stoppable_i | input | N_OUT | Bit i = 1: output i stops while the request is active |
| enable_i | input | N_OUT | Bit i = 0: output i is permanently off |
| clk_o | output | N_OUT | Gated true-leg clocks |
| clkb_o | output | N_OUT | Gated complement-leg clocks |
| oe_o | output | N_OUT | Output-drive enable, 0 = high impedance |

## Verification
A wrong synchronizer depth shows at the ports as a last pulse one rising edge early or late around a request edge. That error is therefore visible within three clock periods of the change to stop_ni. A gate register clocked on the wrong edge produces a truncated high phase on clk_o, or a complement high while clk_i is high, on the very first edge where the gate moves. A swapped stoppable or enable polarity, or a wrong class mask, shows on oe_o and the output levels as soon as the inputs have settled for four cycles.

// File: rtl/clk_stop_gate_pkg.sv
package clk_stop_gate_pkg;

  typedef enum logic {
    CLASS_LOW   = 1'b0,
    CLASS_FLOAT = 1'b1
  } out_class_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;

  function automatic out_class_e class_of(input logic float_bit);
    return float_bit ? CLASS_FLOAT : CLASS_LOW;
  endfunction

endpackage

// File: rtl/csg_stop_sync.sv
module csg_stop_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_ni,
  output logic sync_no
);
  logic [STAGES-1:0] pipe_q;

  // resets to released (1) so nothing stops at power-up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], async_ni};
  end

  assign sync_no = pipe_q[STAGES-1];
endmodule

// File: rtl/csg_gate_cell.sv
module csg_gate_cell
  import clk_stop_gate_pkg::*;
#(
  parameter out_class_e OUT_CLASS = CLASS_LOW
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_o,
  output logic clkb_o,
  output logic oe_o
);
  logic run_t_q;
  logic run_c_q;

  // true-leg gate moves while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_t_q <= 1'b0;
    else         run_t_q <= run_i;
  end

  // complement gate follows half a cycle later, while complement is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_c_q <= 1'b0;
    else         run_c_q <= run_t_q;
  end

  assign clk_o  = clk_i & run_t_q;
  assign clkb_o = ~clk_i & run_c_q;

  generate
    if (OUT_CLASS == CLASS_FLOAT) begin : g_float
      assign oe_o = run_t_q | run_c_q;
    end else begin : g_low
      assign oe_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import clk_stop_gate_pkg::*;
#(
  parameter int unsigned       N_OUT       = 5,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [N_OUT-1:0]  FLOAT_MASK  = 5'b00011
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_ni,
  input  logic [N_OUT-1:0] stoppable_i,
  input  logic [N_OUT-1:0] enable_i,
  output logic [N_OUT-1:0] clk_o,
  output logic [N_OUT-1:0] clkb_o,
  output logic [N_OUT-1:0] oe_o
);
  localparam int unsigned STAGES =
    (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic             stop_sync_n;
  logic [N_OUT-1:0] stop_vec;
  logic [N_OUT-1:0] run;

  csg_stop_sync #(.STAGES(STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .async_ni (stop_ni),
    .sync_no  (stop_sync_n)
  );

  assign stop_vec = {N_OUT{~stop_sync_n}} & stoppable_i;
  assign run      = enable_i & ~stop_vec;

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
      csg_gate_cell #(.OUT_CLASS(class_of(FLOAT_MASK[i]))) u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run[i]),
        .clk_o  (clk_o[i]),
        .clkb_o (clkb_o[i]),
        .oe_o   (oe_o[i])
      );
    end
  endgenerate
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int unsigned      N_OUT       = 5,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [N_OUT-1:0] FLOAT_MASK  = 5'b00011
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stop_ni,
  input logic [N_OUT-1:0] stoppable_i,
  input logic [N_OUT-1:0] enable_i,
  input logic [N_OUT-1:0] clk_o,
  input logic [N_OUT-1:0] clkb_o,
  input logic [N_OUT-1:0] oe_o
);
  logic [2:0] seen_q;
  logic [2:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '1;
      cyc_q  <= '0;
    end else begin
      seen_q <= {seen_q[1:0], stop_ni};
      if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
    end
  end

  // R1 R2 R3 R4
  gate_level_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 3'd4) |->
      (clk_o == ($past(enable_i) & ~($past(stoppable_i) & {N_OUT{~seen_q[2]}}))));

  // R6
  true_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_o == '0);

  // R7
  comp_low_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    clkb_o == '0);

  // R5
  float_quiet_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ((~oe_o) & FLOAT_MASK & (clk_o | clkb_o)) == '0);

  // R5
  low_class_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o | FLOAT_MASK) == '1);
endmodule

bind clk_stop_gate clk_stop_gate_chk #(
  .N_OUT(N_OUT), .SYNC_STAGES(SYNC_STAGES), .FLOAT_MASK(FLOAT_MASK)
) u_chk (.*);

// File: tb/tb_clk_stop_gate.sv
module tb_clk_stop_gate;
  localparam int unsigned      N  = 5;
  localparam logic [N-1:0]     FM = 5'b00011;
  localparam int unsigned      NV = 8;
  // {stop_n, stoppable, enable, expected run}
  localparam logic [15:0] VEC [NV] = '{
    16'b1_11111_11111_11111,
    16'b0_11111_11111_00000,
    16'b0_01001_11111_10110,
    16'b0_00000_11111_11111,
    16'b1_01001_10101_10101,
    16'b0_10101_01110_01010,
    16'b0_00110_11011_11001,
    16'b1_00000_00000_00000
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_n = 1'b1;
  logic [N-1:0] stoppable = '1;
  logic [N-1:0] enable = '1;
  logic [N-1:0] clk_o, clkb_o, oe_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clk_stop_gate #(.N_OUT(N), .SYNC_STAGES(2), .FLOAT_MASK(FM)) dut (
    .clk_i(clk), .rst_ni(rst_n), .stop_ni(stop_n),
    .stoppable_i(stoppable), .enable_i(enable),
    .clk_o(clk_o), .clkb_o(clkb_o), .oe_o(oe_o)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic high_phase(input int dly);
    @(posedge clk);
    #dly;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R8 reset state
    repeat (2) @(posedge clk);
    #2;
    chk("R8 clk_o", clk_o, '0);
    chk("R8 oe_o", oe_o, ~FM);
    #5;
    chk("R8 clkb_o", clkb_o, '0);
    rst_n = 1'b1;

    // table walk: R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      logic [N-1:0] run;
      stop_n    = VEC[v][15];
      stoppable = VEC[v][14:10];
      enable    = VEC[v][9:5];
      run       = VEC[v][4:0];
      repeat (3) @(posedge clk);
      high_phase(2);
      chk("R3/R4 clk_o high", clk_o, run);
      chk("R5 oe_o high", oe_o, run | ~FM);
      #5;
      chk("R7 clkb_o low", clkb_o, run);
      chk("R5 oe_o low", oe_o, run | ~FM);
    end

    // R1 stop latency
    stop_n = 1'b1; stoppable = '1; enable = '1;
    repeat (4) @(posedge clk);
    #7;
    stop_n = 1'b0;
    high_phase(2);
    chk("R1 edge1", clk_o, '1);
    high_phase(2);
    chk("R1 edge2", clk_o, '1);
    #5;
    chk("R7 last complement", clkb_o, '1);
    high_phase(2);
    chk("R1 edge3", clk_o, '0);
    chk("R5 floated", oe_o, ~FM);
    #5;
    chk("R7 complement stopped", clkb_o, '0);

    // R2 release latency, R6 full pulse
    stop_n = 1'b1;
    high_phase(2);
    chk("R2 edge1", clk_o, '0);
    high_phase(2);
    chk("R2 edge2", clk_o, '0);
    high_phase(1);
    chk("R2 edge3 early", clk_o, '1);
    #3;
    chk("R6 edge3 late", clk_o, '1);
    #3;
    chk("R6 low phase", clk_o, '0);
    chk("R7 complement back", clkb_o, '1);

    // R4 disable wins while released
    enable = 5'b01010;
    repeat (3) @(posedge clk);
    high_phase(2);
    chk("R4 disabled", clk_o, 5'b01010);
    chk("R5 disabled float", oe_o, 5'b01010 | ~FM);

    finish_run();
  end
endmodule